// File: doc/BRIEF.md
# Programmable Countdown Interrupt Timer

A 32-bit countdown timer for a per-core interrupt controller. Software reaches four registers through a one-word register port: a timer control register (interrupt vector, mask bit, periodic/one-shot bit), a divide register, a reload value register and a read-only live count register. The count steps down once per divided clock tick. Expiry raises a one-cycle interrupt request unless the mask bit is set. In one-shot mode the count stops at zero. In periodic mode the count reloads from the reload value and keeps going.

Writing the reload value also copies it into the live count and restarts the prescaler. Writing zero there stops the timer. Software can measure elapsed time as the reload value minus the live count. For that use it loads the largest value, 0xFFFFFFFF, and reads the count later.

Control is a three-state machine. `ST_IDLE` holds after reset or after a zero load. A nonzero load moves any state to `ST_COUNT`. From `ST_COUNT`, a tick that takes the count from one to zero in one-shot mode moves to `ST_EXPIRED`. The same move happens on a tick at zero when the mode has since been switched to one-shot. A zero load returns any state to `ST_IDLE`. In periodic mode the machine stays in `ST_COUNT` and reloads on the tick after zero.

Top module: `lct_timer`

## Requirements
- R1: After reset the control register reads 0x0001_0000 (masked, one-shot, vector 0). The divide register, reload value and live count all read 0, and `irq` is low.
- R2: Register addresses are: 0 control, 1 divide, 2 reload value, 3 live count. The divide rate is selected by divide register bits {3,1,0}: 000→2, 001→4, 010→8, 011→16, 100→32, 101→64, 110→128, 111→1. Bit 2 does not affect the rate, and all four bits read back as written.
- R3: A write of N≠0 to the reload value makes the live count read N on the next cycle and restarts the prescaler. With divide D, the count reads N−⌊j/D⌋ j cycles after the write.
- R4: Writing 0 to the reload value stops the timer: the live count reads 0 and no request follows.
- R5: In one-shot mode the live count stays at 0 once it gets there, and exactly one request is raised.
- R6: In periodic mode the count reloads N on the tick after reaching zero, so the count sequence repeats every (N+1)·D cycles.
- R7: Control bit 16 (mask) suppresses the request. Counting proceeds identically whether or not the mask is set.
- R8: `irq` is a one-cycle pulse. It is high in the cycle after the count moves from 1 to 0. `irq_vector` presents control bits [7:0]. Control bit 17 selects periodic mode when set.
- R9: A new divide value takes effect at the next prescaler boundary and leaves the live count unchanged.
- R10: Writes to the live count address are ignored.
- R11: With the reload value at 0xFFFFFFFF, elapsed ticks equal the reload value minus the live count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data (combinational from `reg_addr`) |
| irq | output | 1 | Expiry request pulse |
| irq_vector | output | 8 | Vector to deliver with the request |

## Verification
The hardest case to reach is a divide change in the middle of a prescaler period. It has to land after the count has already stepped once under the old rate. The bench loads a count at divide-by-4 and waits six cycles so the prescaler is partway through its second period. It then switches to divide-by-1 and checks that the old period finishes before the count steps every cycle. A second hard case is a request that would arrive while the timer is masked. Full sweeps over every divide code repeat each configuration with the mask set and clear, and compare the counts, which must match.

// File: rtl/lct_pkg.sv
package lct_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_COUNT   = 2'd1,
        ST_EXPIRED = 2'd2
    } cnt_state_e;

    localparam int ADDR_W = 2;
    localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_DIV  = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_LOAD = 2'd2;
    localparam logic [ADDR_W-1:0] ADDR_CUR  = 2'd3;

    localparam int MASK_BIT = 16;
    localparam int MODE_BIT = 17;
    localparam int DIV_W    = 4;

    // selector {b3,b1,b0} -> log2 of divisor; 3'b111 means divide by one
    function automatic logic [2:0] div_shift(input logic [2:0] sel);
        return (sel == 3'b111) ? 3'd0 : sel + 3'd1;
    endfunction
endpackage

// File: rtl/lct_prescaler.sv
module lct_prescaler #(
    parameter int PRE_W = 7
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       restart,
    input  logic       run,
    input  logic [2:0] shift,
    output logic       tick
);
    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] reload;

    always_comb reload = PRE_W'((32'd1 << shift) - 32'd1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (restart) begin
            pre_q <= reload;
        end else if (run) begin
            if (pre_q == '0) pre_q <= reload;
            else             pre_q <= pre_q - 1'b1;
        end
    end

    assign tick = run && !restart && (pre_q == '0);
endmodule

// File: rtl/lct_regs.sv
module lct_regs
    import lct_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int VEC_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  wdata,
    output logic [VEC_W-1:0]  vec,
    output logic              masked,
    output logic              periodic,
    output logic [DIV_W-1:0]  div_code,
    output logic [CNT_W-1:0]  load_val,
    output logic              load
);
    assign load = wr && (addr == ADDR_LOAD);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec      <= '0;
            masked   <= 1'b1;
            periodic <= 1'b0;
            div_code <= '0;
            load_val <= '0;
        end else if (wr) begin
            unique case (addr)
                ADDR_CTRL: begin
                    vec      <= wdata[VEC_W-1:0];
                    masked   <= wdata[MASK_BIT];
                    periodic <= wdata[MODE_BIT];
                end
                ADDR_DIV:  div_code <= wdata[DIV_W-1:0];
                ADDR_LOAD: load_val <= wdata;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/lct_counter.sv
module lct_counter
    import lct_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] wdata,
    input  logic [CNT_W-1:0] load_val,
    input  logic             periodic,
    input  logic             masked,
    input  logic             tick,
    output logic [CNT_W-1:0] cnt,
    output logic             running,
    output logic             irq
);
    cnt_state_e state_q, state_d;
    logic at_one, at_zero;

    assign at_one  = (cnt == CNT_W'(1));
    assign at_zero = (cnt == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    ;
            ST_COUNT:   if (tick && !periodic && (at_one || at_zero)) state_d = ST_EXPIRED;
            ST_EXPIRED: ;
            default:    state_d = ST_IDLE;
        endcase
        if (load) state_d = (wdata == '0) ? ST_IDLE : ST_COUNT;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            irq <= 1'b0;
        end else begin
            irq <= 1'b0;
            if (load) begin
                cnt <= wdata;
            end else if (state_q == ST_COUNT && tick) begin
                if (at_zero) begin
                    if (periodic) cnt <= load_val;
                end else begin
                    cnt <= cnt - 1'b1;
                    if (at_one && !masked) irq <= 1'b1;
                end
            end
        end
    end

    assign running = (state_q == ST_COUNT);
endmodule

// File: rtl/lct_timer.sv
module lct_timer
    import lct_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int VEC_W = 8,
    parameter int PRE_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [CNT_W-1:0]  reg_wdata,
    output logic [CNT_W-1:0]  reg_rdata,
    output logic              irq,
    output logic [VEC_W-1:0]  irq_vector
);
    logic             masked, periodic, load, tick, running;
    logic [DIV_W-1:0] div_code;
    logic [CNT_W-1:0] load_val, cur_cnt;
    logic [2:0]       shift;

    lct_regs #(.CNT_W(CNT_W), .VEC_W(VEC_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
        .vec(irq_vector), .masked(masked), .periodic(periodic),
        .div_code(div_code), .load_val(load_val), .load(load)
    );

    assign shift = div_shift({div_code[3], div_code[1:0]});

    lct_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .restart(load), .run(running),
        .shift(shift), .tick(tick)
    );

    lct_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .load(load), .wdata(reg_wdata),
        .load_val(load_val), .periodic(periodic), .masked(masked),
        .tick(tick), .cnt(cur_cnt), .running(running), .irq(irq)
    );

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            ADDR_CTRL: begin
                reg_rdata[VEC_W-1:0] = irq_vector;
                reg_rdata[MASK_BIT]  = masked;
                reg_rdata[MODE_BIT]  = periodic;
            end
            ADDR_DIV:  reg_rdata[DIV_W-1:0] = div_code;
            ADDR_LOAD: reg_rdata = load_val;
            default:   reg_rdata = cur_cnt;
        endcase
    end
endmodule

// File: rtl/lct_timer_chk.sv
module lct_timer_chk
    import lct_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_wr,
    input logic [1:0]       reg_addr,
    input logic [CNT_W-1:0] reg_wdata,
    input logic             irq,
    input logic [CNT_W-1:0] cur_cnt,
    input logic [CNT_W-1:0] load_val,
    input logic             masked,
    input logic             periodic
);
    logic ld;
    assign ld = reg_wr && (reg_addr == ADDR_LOAD);

    p_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> (cur_cnt == $past(reg_wdata)));

    p_zero_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ld && reg_wdata == '0) |=> (cur_cnt == '0 && !irq));

    p_oneshot_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_cnt == '0 && !periodic && !ld) |=> (cur_cnt == '0));

    p_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(masked) |-> !irq);

    p_irq_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (cur_cnt == '0));

    p_irq_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    p_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(ld) && cur_cnt != $past(cur_cnt))
            |-> (cur_cnt == $past(cur_cnt) - 1'b1 || cur_cnt == load_val));
endmodule

bind lct_timer lct_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .irq(irq), .cur_cnt(cur_cnt), .load_val(load_val),
    .masked(masked), .periodic(periodic)
);

// File: tb/lct_timer_tb.sv
module lct_timer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;
    logic [7:0]  irq_vector;

    int vectors = 0;
    int fails = 0;
    bit done = 0;

    always #5 clk = ~clk;

    lct_timer u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .irq_vector(irq_vector)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    function automatic int divisor(input logic [3:0] c);
        case ({c[3], c[1:0]})
            3'd0: return 2;   3'd1: return 4;  3'd2: return 8;  3'd3: return 16;
            3'd4: return 32;  3'd5: return 64; 3'd6: return 128; default: return 1;
        endcase
    endfunction

    task automatic start(input logic [3:0] code, input logic [31:0] n,
                         input bit per, input bit msk, input logic [7:0] vec);
        wr(2'd2, 32'd0);
        wr(2'd1, {28'd0, code});
        wr(2'd0, {14'd0, per, msk, 8'd0, vec});
        wr(2'd2, n);
    endtask

    // starts at j=0 (negedge after the load edge); compares live count and irq each cycle
    task automatic run_seq(input int n, input int d, input bit per, input bit msk, input int steps);
        logic [31:0] v;
        int p, ec, ei;
        p = (n + 1) * d;
        for (int j = 0; j <= steps; j++) begin
            if (per) begin
                ec = n - (j % p) / d;
                ei = ((j % p) == n * d) && !msk;
            end else begin
                ec = (j >= n * d) ? 0 : n - j / d;
                ei = (j == n * d) && !msk;
            end
            rd(2'd3, v);
            chk(v, ec, per ? "R6 periodic count" : (msk ? "R7 masked count" : "R5 one-shot count"));
            chk({31'd0, irq}, ei, msk ? "R7 masked irq" : "R8 irq pulse");
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(2'd0, v); chk(v, 32'h0001_0000, "R1 control");
        rd(2'd1, v); chk(v, 0, "R1 divide");
        rd(2'd2, v); chk(v, 0, "R1 reload");
        rd(2'd3, v); chk(v, 0, "R1 count");
        chk({31'd0, irq}, 0, "R1 irq");

        // R2 R6 R8: every divide code, periodic, unmasked
        for (int c = 0; c < 16; c++) begin
            for (int n = 1; n <= 3; n++) begin
                start(4'(c), n, 1'b1, 1'b0, 8'(c * 7 + n));
                run_seq(n, divisor(4'(c)), 1'b1, 1'b0, 2 * (n + 1) * divisor(4'(c)) + 2);
                rd(2'd1, v); chk(v, c, "R2 divide readback");
                chk({24'd0, irq_vector}, c * 7 + n, "R8 vector");
            end
        end

        // R5 R7: one-shot, mask set and clear
        for (int c = 0; c < 16; c++) begin
            if (c[2] == 1'b0) begin
                for (int m = 0; m < 2; m++) begin
                    start(4'(c), 2, 1'b0, m[0], 8'h3C);
                    run_seq(2, divisor(4'(c)), 1'b0, m[0], 4 * divisor(4'(c)) + 3);
                end
            end
        end

        // R3 restart while counting
        start(4'h2, 5, 1'b0, 1'b0, 8'h11);
        repeat (3) @(negedge clk);
        wr(2'd2, 32'd4);
        run_seq(4, 8, 1'b0, 1'b0, 40);

        // R4 zero load stops
        start(4'hB, 5, 1'b1, 1'b0, 8'h22);
        repeat (2) @(negedge clk);
        rd(2'd3, v); chk(v, 3, "R4 before stop");
        wr(2'd2, 32'd0);
        for (int k = 0; k < 20; k++) begin
            rd(2'd3, v); chk(v, 0, "R4 stopped count");
            chk({31'd0, irq}, 0, "R4 stopped irq");
            @(negedge clk);
        end

        // R9 divide change mid-period
        start(4'h1, 10, 1'b0, 1'b1, 8'h33);
        repeat (6) @(negedge clk);
        rd(2'd3, v); chk(v, 9, "R9 before change");
        wr(2'd1, 32'hB);
        rd(2'd3, v); chk(v, 9, "R9 count kept");
        for (int k = 8; k <= 10; k++) begin
            @(negedge clk);
            rd(2'd3, v); chk(v, 16 - k, "R9 new rate");
        end

        // R10 live count is read-only
        start(4'hB, 100, 1'b0, 1'b1, 8'h44);
        wr(2'd3, 32'd5);
        rd(2'd3, v); chk(v, 99, "R10 write ignored");
        rd(2'd2, v); chk(v, 100, "R10 reload intact");

        // R11 full range elapsed ticks
        start(4'hB, 32'hFFFF_FFFF, 1'b0, 1'b1, 8'h55);
        repeat (1000) @(negedge clk);
        rd(2'd3, v); chk(32'hFFFF_FFFF - v, 1000, "R11 elapsed div1");
        start(4'hA, 32'hFFFF_FFFF, 1'b0, 1'b1, 8'h55);
        repeat (1280) @(negedge clk);
        rd(2'd3, v); chk(32'hFFFF_FFFF - v, 10, "R11 elapsed div128");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule